// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This block is a down-counting watchdog that runs on the system clock. Software stores a starting count, picks what should happen on expiry, and then sets the enable bit. The counter then steps down by one on every clock. Software has to write the kick register again and again, and each kick puts the counter back at the stored value. If the counter reaches zero with no kick, the block raises one action: a single-cycle request to reset the core and its peripherals, a non-maskable interrupt request, or an ordinary interrupt request.

The block has two resets. `por_ni` is the power-on reset and clears everything. `rst_ni` is the system reset, which the reset network drives and which the watchdog's own request can trigger. A sticky expiry flag sits only in the power-on domain, so after a reset caused by the watchdog, software can still read the flag and see what caused the reset. Software reaches all state through a single-cycle write strobe with an address and a combinational read-data output.

Register map (2-bit address): 0 = control, 1 = starting count, 2 = kick (write-only, reads 0), 3 = live count (read-only). Control bits: bit 0 = enable, bits 2:1 = action (0 none, 1 reset request, 2 non-maskable interrupt, 3 ordinary interrupt), bit 3 = expiry flag (reads the flag; writing 1 clears it and acknowledges a pending interrupt). All other control bits read 0.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, all three action outputs are 0, control reads 0, the starting count reads all ones and the live count reads 0.
- R2: A control write that sets enable while the timer is disabled copies the starting count into the live count at that edge. After that, the live count drops by 1 on each clock while it is non-zero.
- R3: With a starting count L, if no kick arrives, expiry is registered L+1 clocks after the enabling edge. At that point the expiry flag (control bit 3) sets and only the selected action output responds. Action 0 sets the flag alone.
- R4: When action 1 is selected, `rst_req_o` is high for exactly one clock on expiry.
- R5: When action 2 or 3 is selected, `nmi_o` or `irq_o` respectively goes high on expiry and stays high until a control write with bit 3 set.
- R6: A write to address 2 always reloads the live count from the starting count and restarts the countdown. A kick in the same cycle as the zero count prevents expiry.
- R7: A write to address 1 while enable is set is ignored, and the starting count keeps its value.
- R8: The expiry flag is not changed by `rst_ni`. It is cleared only by a control write with bit 3 set or by `por_ni`.
- R9: After expiry the count holds at zero and fires no further action until a kick or a fresh enable.
- R10: A control write with bit 3 clear leaves the expiry flag and any pending interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| rst_req_o | output | 1 | Core-and-peripheral reset request pulse |
| nmi_o | output | 1 | Non-maskable interrupt request level |
| irq_o | output | 1 | General-purpose interrupt request level |

## Verification
The bench drives a kick in the very cycle the count reaches zero. A design that checks zero before checking the kick would fire there. It also applies a system reset after a reset-action expiry and checks that the flag survives. A flag placed in the wrong reset domain would read 0 at that point. Other checks catch these faults: a starting-count write that slips through while enabled, an interrupt that drops before it is acknowledged, an off-by-one in the expiry cycle, a reset pulse longer than one clock, and a repeated action after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LOAD  = 2'd1;
  localparam logic [1:0] ADDR_KICK  = 2'd2;
  localparam logic [1:0] ADDR_COUNT = 2'd3;

  localparam logic [1:0] ACT_NONE  = 2'd0;
  localparam logic [1:0] ACT_RESET = 2'd1;
  localparam logic [1:0] ACT_NMI   = 2'd2;
  localparam logic [1:0] ACT_IRQ   = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_ACT  = 1;
  localparam int CTRL_STAT = 3;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          W          = 32,
  parameter logic [W-1:0] RESET_LOAD = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         stat_i,
  output logic         en_o,
  output logic [1:0]   act_o,
  output logic [W-1:0] load_o,
  output logic         start_o,
  output logic         kick_o,
  output logic         clr_o,
  output logic [W-1:0] rdata_o
);
  localparam int CTRL_W = CTRL_STAT + 1;

  logic wr_ctrl, wr_load;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_load = wr_en_i && (addr_i == ADDR_LOAD);
  assign kick_o  = wr_en_i && (addr_i == ADDR_KICK);
  assign start_o = wr_ctrl && wdata_i[CTRL_EN] && !en_o;
  assign clr_o   = wr_ctrl && wdata_i[CTRL_STAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      act_o  <= ACT_NONE;
      load_o <= RESET_LOAD;
    end else begin
      if (wr_ctrl) begin
        en_o  <= wdata_i[CTRL_EN];
        act_o <= wdata_i[CTRL_ACT +: 2];
      end
      // count value locked while running
      if (wr_load && !en_o) load_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL:  rdata_o[CTRL_W-1:0] = {stat_i, act_o, en_o};
      ADDR_LOAD:  rdata_o = load_o;
      ADDR_KICK:  rdata_o = '0;
      ADDR_COUNT: rdata_o = cnt_i;
      default:    rdata_o = '0;
    endcase
  end

  AST_LOAD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> $stable(load_o)); // R7
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] load_i,
  input  logic         start_i,
  input  logic         kick_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic tripped_q;
  logic reload;

  assign reload   = start_i || kick_i;
  // kick on the zero cycle wins over expiry
  assign expire_o = en_i && !tripped_q && (cnt_o == '0) && !reload;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      tripped_q <= 1'b0;
    end else if (reload) begin
      cnt_o     <= load_i;
      tripped_q <= 1'b0;
    end else if (en_i && !tripped_q) begin
      if (cnt_o == '0) tripped_q <= 1'b1;
      else             cnt_o     <= cnt_o - 1'b1;
    end
  end

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tripped_q && cnt_o != '0 && !reload) |=> (cnt_o == $past(cnt_o) - 1'b1)); // R2
  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R9
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tripped_q && !reload) |=> (tripped_q && cnt_o == '0)); // R9
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic [1:0] act_i,
  input  logic       clr_i,
  output logic       stat_o,
  output logic       rst_req_o,
  output logic       nmi_o,
  output logic       irq_o
);
  logic rst_n_all;
  assign rst_n_all = por_ni && rst_ni;

  // power-on domain only: survives the reset it requests
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       stat_o <= 1'b0;
    else if (expire_i) stat_o <= 1'b1;
    else if (clr_i)    stat_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_all) begin
    if (!rst_n_all) begin
      rst_req_o <= 1'b0;
      nmi_o     <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      rst_req_o <= expire_i && (act_i == ACT_RESET);
      if (expire_i && act_i == ACT_NMI) nmi_o <= 1'b1;
      else if (clr_i)                   nmi_o <= 1'b0;
      if (expire_i && act_i == ACT_IRQ) irq_o <= 1'b1;
      else if (clr_i)                   irq_o <= 1'b0;
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_all)
    rst_req_o |=> !rst_req_o); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_all)
    (irq_o && !clr_i) |=> irq_o); // R5
  AST_NMI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_all)
    (nmi_o && !clr_i) |=> nmi_o); // R5
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!por_ni)
    (stat_o && !clr_i) |=> stat_o); // R8
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int           W          = 32,
  parameter logic [W-1:0] RESET_LOAD = '1
) (
  input  logic         clk_i,
  input  logic         por_ni,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         rst_req_o,
  output logic         nmi_o,
  output logic         irq_o
);
  logic         rst_n_all;
  logic         en, start, kick, clr, expire, stat;
  logic [1:0]   act;
  logic [W-1:0] load, cnt;

  assign rst_n_all = por_ni && rst_ni;

  wdog_regs #(.W(W), .RESET_LOAD(RESET_LOAD)) u_regs (
    .clk_i, .rst_ni(rst_n_all), .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt), .stat_i(stat), .en_o(en), .act_o(act), .load_o(load),
    .start_o(start), .kick_o(kick), .clr_o(clr), .rdata_o
  );

  wdog_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni(rst_n_all), .en_i(en), .load_i(load),
    .start_i(start), .kick_i(kick), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_action u_act (
    .clk_i, .por_ni, .rst_ni, .expire_i(expire), .act_i(act), .clr_i(clr),
    .stat_o(stat), .rst_req_o, .nmi_o, .irq_o
  );

  AST_ONE_EXPIRY_ACTION: assert property (@(posedge clk_i) disable iff (!rst_n_all)
    rst_req_o |-> stat); // R3
endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         por_n = 1'b0, rst_n = 1'b0;
  logic         wr = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         rst_req, nmi, irq;

  int    vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  wdog_top #(.W(W)) uut (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req), .nmi_o(nmi), .irq_o(irq)
  );

  // behavioural reference
  bit m_en, m_stat, m_rst, m_nmi, m_irq, m_trip;
  int unsigned m_act, m_load, m_cnt;
  bit wc, wl, wk, st, ex, cl;

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n) m_stat = 1'b0;
    if (!rst_n || !por_n) begin
      m_en = 0; m_act = 0; m_load = 32'hFFFF_FFFF; m_cnt = 0; m_trip = 0;
      m_rst = 0; m_nmi = 0; m_irq = 0;
    end else begin
      wc = wr && addr == 2'd0;
      wl = wr && addr == 2'd1;
      wk = wr && addr == 2'd2;
      st = wc && wdata[0] && !m_en;
      cl = wc && wdata[3];
      ex = m_en && !m_trip && m_cnt == 0 && !st && !wk;
      m_rst = ex && m_act == 1;
      if (ex && m_act == 2) m_nmi = 1; else if (cl) m_nmi = 0;
      if (ex && m_act == 3) m_irq = 1; else if (cl) m_irq = 0;
      if (ex) m_stat = 1; else if (cl) m_stat = 0;
      if (st || wk) begin m_cnt = m_load; m_trip = 0; end
      else if (m_en && !m_trip) begin
        if (m_cnt == 0) m_trip = 1; else m_cnt = m_cnt - 1;
      end
      if (wl && !m_en) m_load = wdata;
      if (wc) begin m_en = wdata[0]; m_act = int'(wdata[2:1]); end
    end
  end

  function automatic logic [W-1:0] exp_rdata();
    case (addr)
      2'd0: return W'({m_stat, 2'(m_act), m_en});
      2'd1: return m_load;
      2'd2: return '0;
      default: return m_cnt;
    endcase
  endfunction

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      check(cur_req, "rst_req", W'(rst_req), W'(m_rst));
      check(cur_req, "nmi", W'(nmi), W'(m_nmi));
      check(cur_req, "irq", W'(irq), W'(m_irq));
      check(cur_req, "rdata", rdata, exp_rdata());
    end
  end

  task automatic wreg(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 2'd3; wdata = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic look(logic [1:0] a, logic [W-1:0] exp, string req);
    @(negedge clk); addr = a; #0.5;
    check(req, "readback", rdata, exp);
  endtask

  initial begin
    idle(3);
    por_n = 1; rst_n = 1;
    cur_req = "R1";
    look(2'd0, 32'h0, "R1");
    look(2'd1, 32'hFFFF_FFFF, "R1");
    look(2'd3, 32'h0, "R1");

    cur_req = "R2";
    wreg(2'd1, 32'd10);
    wreg(2'd0, 32'h1);           // enable, action none
    idle(5);
    cur_req = "R3";
    idle(10);
    look(2'd0, 32'h9, "R3");     // flag set, no outputs
    cur_req = "R9";
    idle(8);
    look(2'd3, 32'h0, "R9");
    cur_req = "R10";
    wreg(2'd0, 32'h1);
    look(2'd0, 32'h9, "R10");
    cur_req = "R8";
    wreg(2'd0, 32'h8);           // clear flag, disable
    look(2'd0, 32'h0, "R8");

    cur_req = "R6";
    wreg(2'd1, 32'd20);
    wreg(2'd0, 32'h7);           // enable, interrupt action
    for (int k = 0; k < 4; k++) begin idle(10); wreg(2'd2, 32'h0); end
    cur_req = "R7";
    wreg(2'd1, 32'd3);
    look(2'd1, 32'd20, "R7");
    cur_req = "R5";
    idle(30);
    check("R5", "irq held", W'(irq), W'(1'b1));
    cur_req = "R10";
    wreg(2'd0, 32'h7);
    check("R10", "irq after ack-less write", W'(irq), W'(1'b1));
    cur_req = "R5";
    wreg(2'd0, 32'hF);
    check("R5", "irq acked", W'(irq), W'(1'b0));

    cur_req = "R6";
    wreg(2'd0, 32'h0);
    wreg(2'd1, 32'd4);
    wreg(2'd0, 32'h7);
    idle(3);
    wreg(2'd2, 32'h0);           // kick lands on zero-count cycle
    idle(2);
    check("R6", "no expiry on zero-cycle kick", W'(irq), W'(1'b0));

    cur_req = "R5";
    wreg(2'd0, 32'h0);
    wreg(2'd1, 32'd5);
    wreg(2'd0, 32'h5);           // enable, NMI action
    idle(12);
    check("R5", "nmi held", W'(nmi), W'(1'b1));
    wreg(2'd0, 32'hD);

    cur_req = "R4";
    wreg(2'd0, 32'h0);
    wreg(2'd1, 32'd3);
    wreg(2'd0, 32'h3);           // enable, reset action
    idle(10);
    cur_req = "R8";
    @(negedge clk); rst_n = 0;
    idle(2); rst_n = 1;
    look(2'd0, 32'h8, "R8");
    @(negedge clk); por_n = 0;
    idle(2); por_n = 1;
    look(2'd0, 32'h0, "R8");
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule